// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a flash read path and records the first ECC event that path reports. A strobe for a corrected single-bit error or a strobe for an uncorrectable double-bit error arrives with the failing per-bank offset, the bank index and a flag marking the system memory area. The block stores where the error happened and raises one of two sticky flags. A corrected error drives a maskable interrupt. A detected double error drives a non-maskable request.

Only one event is held at a time. Once either flag is set, later events are dropped and the stored location stays fixed. Software reads the single 32-bit register and releases it by writing 1 to the flags. The write port and read port stand in for a bus. Reads are combinational and writes take effect on the next clock edge.

Top module: `ecc_capture_reg`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00000000, and both `irq_corr` and `nmi_req` are low.
- R2: If `ev_sec` is high and `ev_ded` is low while both flags are clear, the next edge sets the correction flag (bit 30) and loads the location. The offset goes to bits 20:0, the bank to bit 21 (0 = first bank, 1 = second) and the system-area flag to bit 22.
- R3: If `ev_ded` is high while both flags are clear, the next edge sets the detection flag (bit 31) and loads the location in the same fields as R2.
- R4: If both strobes are high in one cycle while both flags are clear, only the detection flag is set.
- R5: While either flag is set, new events change neither flag nor the location fields.
- R6: A write with bit 30 or bit 31 at 1 clears that flag on the next edge. A write with 0 in a flag bit leaves that flag as it was.
- R7: Bit 24 is the correction interrupt enable. Every write loads it. `irq_corr` is high exactly while the correction flag and the enable are both 1.
- R8: `nmi_req` is high exactly while the detection flag is set, whatever the enable holds.
- R9: If a write clears every set flag in the same cycle as an event arrives, the event is captured as if the flags had been clear.
- R10: Bits 23 and 25 to 29 always read 0. Writes to bits 0 to 23 and 25 to 29 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_sec | input | 1 | Strobe for a corrected single-bit error |
| ev_ded | input | 1 | Strobe for a detected double-bit error |
| ev_addr | input | 21 | Failing offset within the bank |
| ev_bank | input | 1 | Failing bank: 0 first, 1 second |
| ev_sysmem | input | 1 | Error lies in the system memory area |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| irq_corr | output | 1 | Maskable correction interrupt |
| nmi_req | output | 1 | Non-maskable detection request |

## Verification
Every result of this block appears one clock edge after its stimulus. This covers a captured event, a clear, an enable write and both interrupt outputs, because the read value and both interrupt lines are combinational views of registers. The bench applies each stimulus on a falling edge, lets exactly one rising edge pass, and compares at the next falling edge against a cycle model written from the requirements. Directed sequences cover each requirement. A long pseudo-random mix of strobes, locations and writes then sweeps the busy, clear and same-cycle combinations.

// File: rtl/ecc_cap_pkg.sv
// Package: shared types for the ECC capture register.
// Assumes: one event kind is recorded per capture; double error outranks single.
package ecc_cap_pkg;
    // Offset from the top of the address field to the enable bit.
    localparam int unsigned IE_GAP = 3;

    // Kind of event granted a capture in the current cycle.
    typedef enum logic [1:0] {
        EVK_NONE = 2'd0,
        EVK_SEC  = 2'd1,
        EVK_DED  = 2'd2
    } ev_kind_e;
endpackage

// File: rtl/ecc_event_arb.sv
// Module: ecc_event_arb
// Decides whether this cycle's error strobe is captured, and as which kind.
// Assumes: the clear requests are applied before the busy test, so a flag
// cleared in this cycle does not block a new event.
module ecc_event_arb
    import ecc_cap_pkg::*;
(
    input  logic     ev_sec,
    input  logic     ev_ded,
    input  logic     corr_q,
    input  logic     ded_q,
    input  logic     clr_corr,
    input  logic     clr_ded,
    output ev_kind_e kind
);
    logic busy_after_clr;

    // Flags as they will stand once this cycle's clears are applied.
    always_comb begin
        busy_after_clr = (corr_q && !clr_corr) || (ded_q && !clr_ded);
    end

    // Grant: double error first, then single error, only when idle.
    always_comb begin
        kind = EVK_NONE;
        if (!busy_after_clr) begin
            if (ev_ded)      kind = EVK_DED;
            else if (ev_sec) kind = EVK_SEC;
        end
    end
endmodule

// File: rtl/ecc_flag_ctrl.sv
// Module: ecc_flag_ctrl
// Holds the sticky correction/detection flags and the interrupt enable.
// Drives the maskable and non-maskable interrupt outputs.
// Assumes: clear requests come from a write with 1 in the flag bit; the
// enable is loaded by every write.
module ecc_flag_ctrl
    import ecc_cap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ev_kind_e kind,
    input  logic     clr_corr,
    input  logic     clr_ded,
    input  logic     ie_we,
    input  logic     ie_wd,
    output logic     corr_q,
    output logic     ded_q,
    output logic     ie_q,
    output logic     irq_corr,
    output logic     nmi_req
);
    // Correction flag: clear first, then set on a granted single error.
    always_ff @(posedge clk) begin
        if (!rst_n)                corr_q <= 1'b0;
        else if (kind == EVK_SEC)  corr_q <= 1'b1;
        else if (clr_corr)         corr_q <= 1'b0;
    end

    // Detection flag: clear first, then set on a granted double error.
    always_ff @(posedge clk) begin
        if (!rst_n)                ded_q <= 1'b0;
        else if (kind == EVK_DED)  ded_q <= 1'b1;
        else if (clr_ded)          ded_q <= 1'b0;
    end

    // Interrupt enable: loaded from every register write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= 1'b0;
        else if (ie_we) ie_q <= ie_wd;
    end

    // Interrupt outputs: the correction one is masked, the detection one is not.
    always_comb begin
        irq_corr = corr_q && ie_q;
        nmi_req  = ded_q;
    end

    // R6
    corr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(corr_q) |-> $past(clr_corr));

    // R6
    ded_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ded_q) |-> $past(clr_ded));

    // R4
    one_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corr_q) |-> !ded_q);
endmodule

// File: rtl/ecc_loc_latch.sv
// Module: ecc_loc_latch
// Stores the location of the captured error: offset, bank and system-area bit.
// Assumes: capture is high only in a cycle where a flag is being set.
module ecc_loc_latch #(
    parameter int unsigned ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_bank,
    input  logic              in_sys,
    output logic [ADDR_W-1:0] addr_q,
    output logic              bank_q,
    output logic              sys_q
);
    // Location fields: loaded only on a granted capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bank_q <= 1'b0;
            sys_q  <= 1'b0;
        end else if (capture) begin
            addr_q <= in_addr;
            bank_q <= in_bank;
            sys_q  <= in_sys;
        end
    end
endmodule

// File: rtl/ecc_capture_reg.sv
// Module: ecc_capture_reg (top)
// First-error ECC capture register with W1C flags, a maskable correction
// interrupt and a non-maskable detection request.
// Assumes: a single register, so the write port has no address; reads are
// combinational. Field layout is derived from ADDR_W and DATA_W.
module ecc_capture_reg
    import ecc_cap_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_sec,
    input  logic              ev_ded,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_bank,
    input  logic              ev_sysmem,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_corr,
    output logic              nmi_req
);
    localparam int unsigned BANK_BIT = ADDR_W;
    localparam int unsigned SYS_BIT  = ADDR_W + 1;
    localparam int unsigned IE_BIT   = ADDR_W + IE_GAP;
    localparam int unsigned CORR_BIT = DATA_W - 2;
    localparam int unsigned DED_BIT  = DATA_W - 1;

    logic              clr_corr;
    logic              clr_ded;
    logic              corr_q;
    logic              ded_q;
    logic              ie_q;
    logic [ADDR_W-1:0] addr_q;
    logic              bank_q;
    logic              sys_q;
    ev_kind_e          kind;

    // Write decode: W1C requests for the two flags.
    always_comb begin
        clr_corr = wr_en && wr_data[CORR_BIT];
        clr_ded  = wr_en && wr_data[DED_BIT];
    end

    ecc_event_arb u_arb (
        .ev_sec   (ev_sec),
        .ev_ded   (ev_ded),
        .corr_q   (corr_q),
        .ded_q    (ded_q),
        .clr_corr (clr_corr),
        .clr_ded  (clr_ded),
        .kind     (kind)
    );

    ecc_flag_ctrl u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .clr_corr (clr_corr),
        .clr_ded  (clr_ded),
        .ie_we    (wr_en),
        .ie_wd    (wr_data[IE_BIT]),
        .corr_q   (corr_q),
        .ded_q    (ded_q),
        .ie_q     (ie_q),
        .irq_corr (irq_corr),
        .nmi_req  (nmi_req)
    );

    ecc_loc_latch #(.ADDR_W(ADDR_W)) u_loc (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (kind != EVK_NONE),
        .in_addr (ev_addr),
        .in_bank (ev_bank),
        .in_sys  (ev_sysmem),
        .addr_q  (addr_q),
        .bank_q  (bank_q),
        .sys_q   (sys_q)
    );

    // Read mux: assemble the register image; unused bits stay zero.
    always_comb begin
        rd_data                = '0;
        rd_data[ADDR_W-1:0]    = addr_q;
        rd_data[BANK_BIT]      = bank_q;
        rd_data[SYS_BIT]       = sys_q;
        rd_data[IE_BIT]        = ie_q;
        rd_data[CORR_BIT]      = corr_q;
        rd_data[DED_BIT]       = ded_q;
    end

    // R2
    sec_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corr_q) |-> $past(ev_sec && !ev_ded));

    // R3
    ded_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ded_q) |-> $past(ev_ded));

    // R5
    loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((corr_q || ded_q) && !wr_en) |=> $stable(rd_data[SYS_BIT:0]));

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_corr |-> (rd_data[IE_BIT] && rd_data[CORR_BIT]));

    // R8
    nmi_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> rd_data[DED_BIT]);
endmodule

// File: tb/sim_ecc_capture_reg.sv
// Bench for ecc_capture_reg: directed cases per requirement, then a long
// pseudo-random sweep checked against a cycle model built from the requirements.
module sim_ecc_capture_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_sec, ev_ded, ev_bank, ev_sysmem, wr_en;
    logic [20:0] ev_addr;
    logic [31:0] wr_data, rd_data;
    logic        irq_corr, nmi_req;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [20:0] m_addr;
    logic        m_bank, m_sys, m_ie, m_c, m_d;

    always #2.5ns clk = ~clk;

    ecc_capture_reg u0 (
        .clk(clk), .rst_n(rst_n), .ev_sec(ev_sec), .ev_ded(ev_ded),
        .ev_addr(ev_addr), .ev_bank(ev_bank), .ev_sysmem(ev_sysmem),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_corr(irq_corr), .nmi_req(nmi_req)
    );

    function automatic logic [31:0] model_img();
        return {m_d, m_c, 5'b0, m_ie, 1'b0, m_sys, m_bank, m_addr};
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (rd_data !== model_img()) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, model_img());
        end
        checks++;
        if (irq_corr !== (m_c & m_ie) || nmi_req !== m_d) begin
            errors++;
            $display("FAIL %s irq/nmi actual=%b%b expected=%b%b", tag,
                     irq_corr, nmi_req, m_c & m_ie, m_d);
        end
    endtask

    // One cycle: drive after a falling edge, update model, check after the rising edge.
    task automatic cyc(input logic sec, input logic ded, input logic [20:0] a,
                       input logic b, input logic s, input logic we,
                       input logic [31:0] wd, input string tag);
        logic c_n, d_n;
        ev_sec = sec; ev_ded = ded; ev_addr = a; ev_bank = b; ev_sysmem = s;
        wr_en = we; wr_data = wd;
        c_n = m_c & ~(we & wd[30]);
        d_n = m_d & ~(we & wd[31]);
        if (we) m_ie = wd[24];
        if ((sec | ded) && !c_n && !d_n) begin
            if (ded) d_n = 1'b1; else c_n = 1'b1;
            m_addr = a; m_bank = b; m_sys = s;
        end
        m_c = c_n; m_d = d_n;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0; ev_sec = 1'b1; ev_ded = 1'b1; ev_addr = '1; ev_bank = 1'b1;
        ev_sysmem = 1'b1; wr_en = 1'b1; wr_data = '1;
        m_addr = '0; m_bank = 0; m_sys = 0; m_ie = 0; m_c = 0; m_d = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ev_sec = 0; ev_ded = 0; wr_en = 0; wr_data = '0;
        // R1 reset state
        compare("R1");

        // R2 single error captured with location
        cyc(1, 0, 21'h1FFFF0, 1, 0, 0, 32'h0, "R2");
        // R5 later events ignored while busy
        cyc(0, 1, 21'h000123, 0, 1, 0, 32'h0, "R5");
        cyc(1, 0, 21'h0ABCDE, 0, 1, 0, 32'h0, "R5");
        // R7 enable on -> irq; enable off -> no irq
        cyc(0, 0, 21'h0, 0, 0, 1, 32'h0100_0000, "R7");
        cyc(0, 0, 21'h0, 0, 0, 1, 32'h0000_0000, "R7");
        // R6 write 0 to flags: no effect
        cyc(0, 0, 21'h0, 0, 0, 1, 32'h0000_0000, "R6");
        // R6 write 1 clears correction flag
        cyc(0, 0, 21'h0, 0, 0, 1, 32'h4000_0000, "R6");
        // R3 double error captured; R8 nmi with enable at 0
        cyc(0, 1, 21'h00F0F0, 0, 1, 0, 32'h0, "R3");
        cyc(0, 0, 21'h0, 0, 0, 0, 32'h0, "R8");
        // R6 clearing the wrong flag leaves detection set
        cyc(0, 0, 21'h0, 0, 0, 1, 32'h4000_0000, "R6");
        // R9 clear and new event same cycle: captured
        cyc(1, 0, 21'h155555, 1, 1, 1, 32'h8100_0000, "R9");
        // R4 both strobes at once: detection only
        cyc(0, 0, 21'h0, 0, 0, 1, 32'hC000_0000, "R6");
        cyc(1, 1, 21'h0AAAAA, 1, 0, 0, 32'h0, "R4");
        // R10 writes to status fields change nothing but the enable
        cyc(0, 0, 21'h0, 0, 0, 1, 32'h3FFF_FFFF, "R10");
        cyc(0, 0, 21'h0, 0, 0, 1, 32'h3EFF_FFFF, "R10");

        // Pseudo-random sweep over strobes, locations and writes.
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [31:0] wd;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            we = (lfsr[3:0] < 4'd4);
            wd = {lfsr[31:30], lfsr[29:0] ^ {lfsr[14:0], lfsr[29:15]}};
            cyc(lfsr[5] & lfsr[6], lfsr[7] & lfsr[8] & lfsr[9], lfsr[30:10],
                lfsr[11], lfsr[12], we, wd, "R5_R9_mix");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule